// File: doc/BRIEF.md
# Serial Transmitter with Line-Break Control

This block serializes bytes onto a single transmit line. Software-side logic pushes bytes into a small internal queue. Each time the shared baud tick pulses, the transmitter moves on by one bit period. Every byte goes out as one low start bit, the data bits least significant first, and one high stop bit. Between characters the line rests high.

A line-break request forces the line to a continuous low level. The request is only looked at on bit boundaries. A character that has already started is always completed before the break begins. When the request is withdrawn, the line is held high for a fixed number of mark periods. Any bytes queued in the meantime then go out in their original order.

Three controls can stop the transmitter:

- The module enable and the transmit enable work together as a run gate. Dropping either one aborts the frame in progress and parks the line high. The aborted byte is lost, but the queue keeps its contents.
- A low-power gate (doze-disable AND system doze) freezes the transmitter where it stands and shows a high line while the gate is active.

Top module: `uart_brk_tx`

## Requirements
- R1: Frame format. A frame starts on a baud tick at which the transmitter is free, no break is latched and the queue is not empty. It carries start bit 0, then data bits 0 to 7 in that order, then stop bit 1. Each bit lasts exactly one tick interval, and the line changes on the clock edge that samples the tick.
- R2: The latched break request is evaluated only on baud ticks. If it is set when a frame ends (at the tick closing the stop bit), or on a tick while the transmitter is free, `txd` goes to 0 from that tick on. It stays 0 until a tick finds the latch cleared.
- R3: When a tick finds the break latch cleared, `txd` is held at 1 for exactly MARK_BITS (default 2) tick intervals. Only then may a new frame or a new break begin.
- R4: Bytes written during a break or during the mark interval are kept. After the marks they are sent in write order.
- R5: The break latch copies `brk_req` on every clock while `mod_en` and `tx_en` are both 1. Otherwise it keeps its value, and `brk_req` has no effect.
- R6: While `mod_en` or `tx_en` is 0, `txd` is 1 in that same cycle. A frame in progress is dropped and not resent later. Queued bytes are kept.
- R7: While `doze_dis` and `doze_in` are both 1, `txd` is 1 and the transmitter does not advance on ticks. Once the gate clears, it continues from the exact bit where it stopped. `doze_in` alone has no effect.
- R8: The queue holds FIFO_DEPTH (default 8) bytes. `fifo_empty` and `fifo_full` reflect the count before the current clock edge.
- R9: A write while `fifo_full` is 1 is discarded. `overflow` is then 1 for exactly the following cycle.
- R10: `tx_idle` is 1 exactly when the queue is empty and no frame, break or mark interval is in progress.
- R11: After reset the break latch is 0, the queue is empty, `txd` is 1, `tx_idle` is 1 and `overflow` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Push `wr_data` into the queue |
| wr_data | input | 8 | Byte to transmit |
| baud_tick | input | 1 | One-cycle pulse marking each bit boundary |
| mod_en | input | 1 | Module enable |
| tx_en | input | 1 | Transmit enable |
| brk_req | input | 1 | Line-break request |
| doze_dis | input | 1 | Stop the transmitter during system doze |
| doze_in | input | 1 | System doze indication |
| txd | output | 1 | Serial transmit line |
| fifo_full | output | 1 | Queue full |
| fifo_empty | output | 1 | Queue empty |
| overflow | output | 1 | Pulse: a write was dropped |
| tx_idle | output | 1 | Nothing queued or in flight |

## Verification
The bench builds the block with the default parameters: 8 data bits, 8 queue entries and 2 mark periods. The baud tick pulses every fourth clock. This short bit period lets a full queue drain, and lets a break with queued bytes and a mid-frame abort all happen within a few thousand cycles. A queue depth of 8 means nine back-to-back writes while the run gate is off are enough to reach the overflow path. The 4-clock bit period also leaves room to drop the run gate or raise doze partway through a bit.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FRAME = 2'd1,
    ST_BREAK = 2'd2,
    ST_MARK  = 2'd3
  } tx_state_e;
endpackage

// File: rtl/uart_brk_fifo.sv
module uart_brk_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic              full,
  output logic              empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wptr, rptr;
  logic [CNT_W-1:0]  count;
  logic              do_push, do_pop;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= ptr_next(wptr);
      if (do_pop)  rptr <= ptr_next(rptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/uart_brk_seq.sv
module uart_brk_seq
  import uart_brk_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int MARK_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              halt,
  input  logic              tick,
  input  logic              brk,
  input  logic              q_empty,
  input  logic [DATA_W-1:0] q_head,
  output logic              pop,
  output logic              line_raw,
  output tx_state_e         state
);
  localparam int FRAME_LEN = DATA_W + 2;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam int MC_W      = $clog2(MARK_BITS + 1);

  logic [FRAME_LEN-1:0] shreg;
  logic [IDX_W-1:0]     idx;
  logic [MC_W-1:0]      mcnt;
  logic                 step, boundary;

  function automatic logic [FRAME_LEN-1:0] pack_frame(input logic [DATA_W-1:0] d);
    return {1'b1, d, 1'b0};
  endfunction

  assign step     = run && !halt && tick;
  assign boundary = (state == ST_IDLE) ||
                    (state == ST_FRAME && idx == IDX_W'(FRAME_LEN - 1)) ||
                    (state == ST_MARK  && mcnt == MC_W'(MARK_BITS - 1));
  assign pop      = step && boundary && !brk && !q_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      shreg <= '1;
      idx   <= '0;
      mcnt  <= '0;
    end else if (!run) begin
      state <= ST_IDLE;
      idx   <= '0;
      mcnt  <= '0;
    end else if (step) begin
      if (boundary) begin
        idx  <= '0;
        mcnt <= '0;
        if (brk)           state <= ST_BREAK;
        else if (!q_empty) begin
          state <= ST_FRAME;
          shreg <= pack_frame(q_head);
        end else           state <= ST_IDLE;
      end else begin
        case (state)
          ST_FRAME: begin
            shreg <= {1'b1, shreg[FRAME_LEN-1:1]};
            idx   <= idx + 1'b1;
          end
          ST_BREAK: if (!brk) begin
            state <= ST_MARK;
            mcnt  <= '0;
          end
          ST_MARK:  mcnt <= mcnt + 1'b1;
          default:  state <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    case (state)
      ST_FRAME: line_raw = shreg[0];
      ST_BREAK: line_raw = 1'b0;
      default:  line_raw = 1'b1;
    endcase
  end
endmodule

// File: rtl/uart_brk_tx.sv
module uart_brk_tx
  import uart_brk_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 8,
  parameter int MARK_BITS  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              baud_tick,
  input  logic              mod_en,
  input  logic              tx_en,
  input  logic              brk_req,
  input  logic              doze_dis,
  input  logic              doze_in,
  output logic              txd,
  output logic              fifo_full,
  output logic              fifo_empty,
  output logic              overflow,
  output logic              tx_idle
);
  logic              run_gate, doze_gate, brk_lat, pop, line_raw;
  logic [DATA_W-1:0] q_head;
  tx_state_e         seq_state;
  logic [1:0]        fsm_state;

  assign run_gate  = mod_en && tx_en;
  assign doze_gate = doze_dis && doze_in;
  assign fsm_state = seq_state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        brk_lat <= 1'b0;
    else if (run_gate) brk_lat <= brk_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) overflow <= 1'b0;
    else        overflow <= wr_en && fifo_full;
  end

  uart_brk_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(wr_en), .push_data(wr_data),
    .pop(pop), .head(q_head), .full(fifo_full), .empty(fifo_empty)
  );

  uart_brk_seq #(.DATA_W(DATA_W), .MARK_BITS(MARK_BITS)) u_seq (
    .clk(clk), .rst_n(rst_n), .run(run_gate), .halt(doze_gate),
    .tick(baud_tick), .brk(brk_lat), .q_empty(fifo_empty), .q_head(q_head),
    .pop(pop), .line_raw(line_raw), .state(seq_state)
  );

  assign txd     = (run_gate && !doze_gate) ? line_raw : 1'b1;
  assign tx_idle = fifo_empty && (seq_state == ST_IDLE);
endmodule

// File: rtl/uart_brk_tx_chk.sv
module uart_brk_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mod_en,
  input logic       tx_en,
  input logic       doze_dis,
  input logic       doze_in,
  input logic       baud_tick,
  input logic       wr_en,
  input logic       fifo_full,
  input logic       fifo_empty,
  input logic       overflow,
  input logic       tx_idle,
  input logic       txd,
  input logic       brk_lat,
  input logic [1:0] fsm_state
);
  // R6
  disabled_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mod_en || !tx_en) |-> txd);
  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> $past(wr_en && fifo_full));
  // R8
  full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_full && fifo_empty));
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_idle |-> (fifo_empty && txd));
  // R5
  brk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mod_en && tx_en) |=> $stable(brk_lat));
  // R7
  doze_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && tx_en && doze_dis && doze_in) |=> $stable(fsm_state));
  // R2
  break_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_state == 2'd2 && mod_en && tx_en && !(doze_dis && doze_in)) |-> !txd);
  // R2
  break_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_state != 2'd2 && !baud_tick) |=> fsm_state != 2'd2);
endmodule

bind uart_brk_tx uart_brk_tx_chk u_chk (.*);

// File: tb/tb_uart_brk_tx.sv
module tb_uart_brk_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       baud_tick = 1'b0;
  logic       mod_en = 1'b0, tx_en = 1'b0, brk_req = 1'b0;
  logic       doze_dis = 1'b0, doze_in = 1'b0;
  logic       txd, fifo_full, fifo_empty, overflow, tx_idle;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  uart_brk_tx dut (.*);

  // reference model state
  byte unsigned q[$];
  int  m_st = 0;      // 0 free, 1 frame, 2 break, 3 mark
  int  m_idx = 0, m_cnt = 0;
  byte unsigned m_cur = 0;
  bit  m_brk = 0, m_ovf = 0;
  int  div = 0;

  always @(negedge clk) begin
    baud_tick = (div == 3);
    div = (div + 1) % 4;
  end

  function automatic void decide();
    m_idx = 0; m_cnt = 0;
    if (m_brk) m_st = 2;
    else if (q.size() != 0) begin m_cur = q.pop_front(); m_st = 1; end
    else m_st = 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_st = 0; m_idx = 0; m_cnt = 0; m_brk = 0; m_ovf = 0;
    end else begin
      bit en, halt, was_full;
      en = mod_en && tx_en;
      halt = doze_dis && doze_in;
      was_full = (q.size() == 8);
      if (!en) begin
        m_st = 0; m_idx = 0; m_cnt = 0;
      end else if (!halt && baud_tick) begin
        case (m_st)
          0: decide();
          1: if (m_idx == 9) decide(); else m_idx++;
          2: if (!m_brk) begin m_st = 3; m_cnt = 0; end
          default: if (m_cnt == 1) decide(); else m_cnt++;
        endcase
      end
      if (en) m_brk = brk_req;
      m_ovf = wr_en && was_full;
      if (wr_en && !was_full) q.push_back(wr_data);
    end
  end

  function automatic bit exp_line();
    if (!(mod_en && tx_en) || (doze_dis && doze_in)) return 1'b1;
    case (m_st)
      1: if (m_idx == 0) return 1'b0;
         else if (m_idx == 9) return 1'b1;
         else return m_cur[m_idx-1];
      2: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  function automatic string line_tag();
    if (!(mod_en && tx_en)) return "R6";
    if (doze_dis && doze_in) return "R7";
    case (m_st)
      1: return "R1/R4";
      2: return "R2";
      3: return "R3";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cycle %0d: actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      check(txd == exp_line(), line_tag(), txd, exp_line());
      check(fifo_empty == (q.size() == 0), "R8 empty", fifo_empty, q.size() == 0);
      check(fifo_full == (q.size() == 8), "R8 full", fifo_full, q.size() == 8);
      check(overflow == m_ovf, "R9", overflow, m_ovf);
      check(tx_idle == (q.size() == 0 && m_st == 0), "R10", tx_idle,
            q.size() == 0 && m_st == 0);
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic put(input byte unsigned b);
    @(negedge clk); wr_en = 1'b1; wr_data = b;
    @(negedge clk); wr_en = 1'b0;
  endtask

  initial begin
    wait_cyc(3);
    // R11 reset state
    check(txd == 1'b1, "R11 txd", txd, 1);
    check(tx_idle == 1'b1, "R11 idle", tx_idle, 1);
    check(fifo_empty == 1'b1 && overflow == 1'b0, "R11 fifo", fifo_empty, 1);
    rst_n = 1'b1;
    wait_cyc(2);
    mod_en = 1'b1; tx_en = 1'b1;
    // R1 plain frames
    put(8'hA5); put(8'h3C);
    wait_cyc(120);
    // R2 R3 R4 break after character, writes during break
    put(8'h81); put(8'hF0);
    wait_cyc(10);
    brk_req = 1'b1;
    wait_cyc(30);
    put(8'h55); put(8'h0F);
    wait_cyc(100);
    brk_req = 1'b0;
    wait_cyc(250);
    // R9 overflow while transmit gate closed, R5 break ignored
    tx_en = 1'b0;
    brk_req = 1'b1;
    for (int i = 0; i < 10; i++) put(8'(8'h10 + i));
    wait_cyc(5);
    brk_req = 1'b0;
    wait_cyc(3);
    tx_en = 1'b1;
    wait_cyc(360);
    // R6 abort mid-frame
    put(8'h12); put(8'h34);
    wait_cyc(58);
    mod_en = 1'b0;
    wait_cyc(9);
    mod_en = 1'b1;
    wait_cyc(120);
    // R7 doze
    put(8'h6B);
    wait_cyc(21);
    doze_in = 1'b1;
    wait_cyc(18);
    doze_dis = 1'b1;
    wait_cyc(27);
    doze_in = 1'b0;
    wait_cyc(80);
    // break from free state then re-enable with latch held
    brk_req = 1'b1;
    wait_cyc(20);
    mod_en = 1'b0; brk_req = 1'b0;
    wait_cyc(10);
    brk_req = 1'b1;
    mod_en = 1'b1;
    wait_cyc(20);
    brk_req = 1'b0;
    wait_cyc(40);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #4000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule